// File: doc/BRIEF.md
# Partial-Word Load/Store Merge Sequencer

This block carries out the left and right partial-word loads and stores of a 32-bit little-endian core. The core supplies an unaligned byte address, a register value and a register index. The block always reads the word that holds that address, using the address with its low two bits cleared. It then merges bytes according to direction and offset. A load merges the memory bytes into the old contents of the destination register, not into zero-extended data. A store merges register bytes into the memory word it has just read, then writes the merged word back to the same aligned address.

A finite state machine runs each operation: `ST_IDLE` → `ST_RD_REQ` → `ST_RD_WAIT` → (`ST_WR_REQ` for stores only) → `ST_FINISH` → `ST_IDLE`. `ST_IDLE` moves to `ST_RD_REQ` on `start`. `ST_RD_REQ` moves to `ST_RD_WAIT` on `mem_gnt`. `ST_RD_WAIT` moves on `mem_rvalid`: stores go to `ST_WR_REQ` and loads go to `ST_FINISH`. `ST_WR_REQ` moves to `ST_FINISH` on `mem_gnt`. `ST_FINISH` always returns to `ST_IDLE`.

The block remembers the result of the last completed load. A following load to the same register index merges into that remembered value instead of `reg_in`. A left/right pair therefore completes back to back, without waiting for the register file to be written.

Top module: `uwm_unit`

## Requirements
- R1: Every memory request carries `addr` with bits 1:0 cleared and bits 31:2 unchanged.
- R2: Load-left with offset o (`addr[1:0]`) puts memory bytes 0..o into result bytes 3-o..3. The lower 3-o bytes come from the old register value. Offset 3 returns the memory word.
- R3: Load-right with offset o puts memory bytes o..3 into result bytes 0..3-o. The upper o bytes come from the old register value. Offset 0 returns the memory word.
- R4: Store-left with offset o puts register bytes 3-o..3 into written bytes 0..o. The rest of the written word keeps the memory bytes that were read. Offset 3 writes the register whole.
- R5: Store-right with offset o puts register bytes 0..3-o into written bytes o..3. The rest keeps the memory bytes that were read. Offset 0 writes the register whole.
- R6: A store issues a read (`mem_we`=0) and then a write (`mem_we`=1) to the same aligned address, with `mem_wdata` equal to the merged word. A load issues only a read.
- R7: A request keeps `mem_req`, `mem_we` and `mem_addr` steady until the cycle in which `mem_gnt` is high.
- R8: `done` is high for exactly one cycle. That cycle follows the `mem_rvalid` cycle for a load, or the write-grant cycle for a store. While `done` is high, `result` holds the merged word and `result_idx` holds the register index.
- R9: A load whose `reg_idx` equals the index of the most recently completed load merges into that load's result and ignores `reg_in`.
- R10: A completed store cancels forwarding. A load to a different index also uses `reg_in`.
- R11: `start` is ignored while `busy` is high. The running operation's address and data stay as they were, and no further operation follows.
- R12: After reset the block is idle: `busy`, `mem_req` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| op_store | input | 1 | 1 = store, 0 = load |
| op_left | input | 1 | 1 = left variant, 0 = right variant |
| addr | input | 32 | Unaligned byte address |
| reg_in | input | 32 | Old destination value (load) or source value (store) |
| reg_idx | input | 5 | Register index of the operation |
| busy | output | 1 | High whenever the state machine is not idle |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Merged word (load result, or word written for a store) |
| result_idx | output | 5 | Register index belonging to `result` |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write request, 0 = read request |
| mem_addr | output | 32 | Aligned word address |
| mem_wdata | output | 32 | Merged store data |
| mem_gnt | input | 1 | Memory accepts the current request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Aligned word read from memory |

## Verification
The assertions rely on a well-behaved memory. It raises `mem_gnt` only while a request is pending, and it raises `mem_rvalid` only in a cycle after a read grant, once per read. The bench memory model follows this rule. It grants after a random delay of 0 to 3 cycles and returns data 0 to 3 cycles after the grant. It pulses `start` only when the block is idle, except for deliberate extra pulses during `ST_RD_REQ` that check they are ignored. Register indices come from a small pool, so that forwarding between consecutive loads happens often.

// File: rtl/uwm_pkg.sv
package uwm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WR_REQ,
        ST_FINISH
    } uwm_state_e;

    typedef struct packed {
        logic is_store;
        logic is_left;
    } uwm_op_t;

endpackage

// File: rtl/uwm_load_merge.sv
// Merges an aligned memory word into the old register contents.
module uwm_load_merge #(
    parameter int DW = 32,
    localparam int NB = DW / 8,
    localparam int OW = $clog2(NB)
) (
    input  logic          is_left,
    input  logic [OW-1:0] ofs,
    input  logic [DW-1:0] mem_word,
    input  logic [DW-1:0] old_word,
    output logic [DW-1:0] merged
);
    localparam logic [DW-1:0] ALL1 = '1;

    int sh;

    always_comb begin
        if (is_left) begin
            // memory low bytes climb to the top of the register
            sh     = 8 * (NB - 1 - int'(ofs));
            merged = (mem_word << sh) | (old_word & ~(ALL1 << sh));
        end else begin
            // memory high bytes drop to the bottom of the register
            sh     = 8 * int'(ofs);
            merged = (mem_word >> sh) | (old_word & ~(ALL1 >> sh));
        end
    end
endmodule

// File: rtl/uwm_store_merge.sv
// Merges register bytes into the aligned memory word read back.
module uwm_store_merge #(
    parameter int DW = 32,
    localparam int NB = DW / 8,
    localparam int OW = $clog2(NB)
) (
    input  logic          is_left,
    input  logic [OW-1:0] ofs,
    input  logic [DW-1:0] mem_word,
    input  logic [DW-1:0] src_word,
    output logic [DW-1:0] merged
);
    localparam logic [DW-1:0] ALL1 = '1;

    int sh;

    always_comb begin
        if (is_left) begin
            sh     = 8 * (NB - 1 - int'(ofs));
            merged = (src_word >> sh) | (mem_word & ~(ALL1 >> sh));
        end else begin
            sh     = 8 * int'(ofs);
            merged = (src_word << sh) | (mem_word & ~(ALL1 << sh));
        end
    end
endmodule

// File: rtl/uwm_unit.sv
module uwm_unit #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int IW = 5,
    localparam int NB = DW / 8,
    localparam int OW = $clog2(NB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          op_store,
    input  logic          op_left,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] reg_in,
    input  logic [IW-1:0] reg_idx,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] result,
    output logic [IW-1:0] result_idx,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_gnt,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata
);
    import uwm_pkg::*;

    uwm_state_e    state_q, state_d;
    uwm_op_t       op_q;
    logic [OW-1:0] ofs_q;
    logic [AW-1:0] base_q;
    logic [DW-1:0] src_q;
    logic [IW-1:0] idx_q;
    logic [DW-1:0] mem_q;

    logic          fwd_valid_q;
    logic [IW-1:0] fwd_idx_q;
    logic [DW-1:0] fwd_data_q;

    logic [DW-1:0] ld_merged;
    logic [DW-1:0] st_merged;
    logic          accept;
    logic          use_fwd;

    assign accept  = (state_q == ST_IDLE) && start;
    assign use_fwd = fwd_valid_q && !op_store && (reg_idx == fwd_idx_q);

    uwm_load_merge #(.DW(DW)) u_ld_merge (
        .is_left  (op_q.is_left),
        .ofs      (ofs_q),
        .mem_word (mem_q),
        .old_word (src_q),
        .merged   (ld_merged)
    );

    uwm_store_merge #(.DW(DW)) u_st_merge (
        .is_left  (op_q.is_left),
        .ofs      (ofs_q),
        .mem_word (mem_q),
        .src_word (src_q),
        .merged   (st_merged)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start)      state_d = ST_RD_REQ;
            ST_RD_REQ:  if (mem_gnt)    state_d = ST_RD_WAIT;
            ST_RD_WAIT: if (mem_rvalid) state_d = op_q.is_store ? ST_WR_REQ : ST_FINISH;
            ST_WR_REQ:  if (mem_gnt)    state_d = ST_FINISH;
            ST_FINISH:                  state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy       = 1'b1;
        done       = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = base_q;
        mem_wdata  = st_merged;
        result     = op_q.is_store ? st_merged : ld_merged;
        result_idx = idx_q;
        unique case (state_q)
            ST_IDLE:    busy = 1'b0;
            ST_RD_REQ:  mem_req = 1'b1;
            ST_RD_WAIT: ;
            ST_WR_REQ:  begin mem_req = 1'b1; mem_we = 1'b1; end
            ST_FINISH:  done = 1'b1;
            default:    busy = 1'b0;
        endcase
    end

    // operation capture and read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= '0;
            ofs_q  <= '0;
            base_q <= '0;
            src_q  <= '0;
            idx_q  <= '0;
            mem_q  <= '0;
        end else begin
            if (accept) begin
                op_q.is_store <= op_store;
                op_q.is_left  <= op_left;
                ofs_q         <= addr[OW-1:0];
                base_q        <= {addr[AW-1:OW], {OW{1'b0}}};
                src_q         <= use_fwd ? fwd_data_q : reg_in;
                idx_q         <= reg_idx;
            end
            if ((state_q == ST_RD_WAIT) && mem_rvalid)
                mem_q <= mem_rdata;
        end
    end

    // forwarding slot: last completed load result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fwd_valid_q <= 1'b0;
            fwd_idx_q   <= '0;
            fwd_data_q  <= '0;
        end else if (state_q == ST_FINISH) begin
            if (op_q.is_store) begin
                fwd_valid_q <= 1'b0;
            end else begin
                fwd_valid_q <= 1'b1;
                fwd_idx_q   <= idx_q;
                fwd_data_q  <= ld_merged;
            end
        end
    end
endmodule

// File: rtl/uwm_checker.sv
module uwm_checker #(
    parameter int AW = 32,
    parameter int DW = 32,
    localparam int OW = $clog2(DW / 8)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          op_store,
    input logic          busy,
    input logic          done,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          mem_gnt,
    input logic          mem_rvalid
);
    logic [AW-1:0] rd_addr_q;
    logic          cur_store_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_addr_q   <= '0;
            cur_store_q <= 1'b0;
        end else begin
            if (start && !busy)                 cur_store_q <= op_store;
            if (mem_req && !mem_we && mem_gnt)  rd_addr_q   <= mem_addr;
        end
    end

    assert_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[OW-1:0] == '0));

    assert_wr_same_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_addr == rd_addr_q));

    assert_no_load_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> cur_store_q);

    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(mem_rvalid) || $past(mem_req && mem_we && mem_gnt)));

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !done));
endmodule

bind uwm_unit uwm_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .op_store   (op_store),
    .busy       (busy),
    .done       (done),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_gnt    (mem_gnt),
    .mem_rvalid (mem_rvalid)
);

// File: tb/uwm_unit_tb.sv
module uwm_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, op_store = 1'b0, op_left = 1'b0;
    logic [31:0] addr = '0, reg_in = '0;
    logic [4:0]  reg_idx = '0;
    logic        busy, done, mem_req, mem_we;
    logic [31:0] result, mem_addr, mem_wdata;
    logic [4:0]  result_idx;
    logic        mem_gnt = 1'b0, mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;

    // bench forwarding model
    bit          m_fv = 1'b0;
    logic [4:0]  m_fi = '0;
    logic [31:0] m_fd = '0;

    always #2.5 clk = ~clk;

    uwm_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_store(op_store),
        .op_left(op_left), .addr(addr), .reg_in(reg_in), .reg_idx(reg_idx),
        .busy(busy), .done(done), .result(result), .result_idx(result_idx),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] byt(input logic [31:0] w, input int i);
        return w[8*i +: 8];
    endfunction

    // byte-wise reference merges
    function automatic logic [31:0] ref_merge(input bit st, input bit lf, input int o,
                                               input logic [31:0] m, input logic [31:0] r);
        logic [31:0] v;
        for (int b = 0; b < 4; b++) begin
            if (!st && lf)       v[8*b +: 8] = (b >= 3 - o) ? byt(m, b - (3 - o)) : byt(r, b);
            else if (!st && !lf) v[8*b +: 8] = (b <= 3 - o) ? byt(m, b + o)       : byt(r, b);
            else if (st && lf)   v[8*b +: 8] = (b <= o)     ? byt(r, b + 3 - o)   : byt(m, b);
            else                 v[8*b +: 8] = (b >= o)     ? byt(r, b - o)       : byt(m, b);
        end
        return v;
    endfunction

    task automatic run_op(input bit st, input bit lf, input logic [31:0] a,
                          input logic [31:0] rv, input logic [4:0] ix,
                          input logic [31:0] mw, input int gd1, input int rl,
                          input int gd2, input bit poke, output logic [31:0] got);
        logic [31:0] old, exp, al;
        string tag;
        old = (!st && m_fv && ix == m_fi) ? m_fd : rv;
        exp = ref_merge(st, lf, int'(a[1:0]), mw, old);
        al  = {a[31:2], 2'b00};
        tag = st ? (lf ? "R4" : "R5") : (lf ? "R2" : "R3");

        @(negedge clk);
        start = 1'b1; op_store = st; op_left = lf; addr = a; reg_in = rv; reg_idx = ix;
        @(negedge clk);
        start = 1'b0;
        check(mem_req && !mem_we && mem_addr == al, "R1", mem_addr, al);
        for (int i = 0; i < gd1; i++) begin
            if (poke) begin
                start = 1'b1; op_store = ~st; addr = a ^ 32'h0000_0104;
                reg_in = ~rv; reg_idx = ix + 5'd1;
            end
            @(negedge clk);
            start = 1'b0;
            check(mem_req && !mem_we && mem_addr == al, poke ? "R11" : "R7", mem_addr, al);
        end
        mem_gnt = 1'b1;
        @(negedge clk);
        mem_gnt = 1'b0;
        for (int i = 0; i < rl; i++) begin
            check(!mem_req, "R6", {31'd0, mem_req}, 32'd0);
            @(negedge clk);
        end
        mem_rvalid = 1'b1; mem_rdata = mw;
        @(negedge clk);
        mem_rvalid = 1'b0; mem_rdata = $urandom;
        if (st) begin
            check(mem_req && mem_we && mem_addr == al, "R6", mem_addr, al);
            check(mem_wdata == exp, tag, mem_wdata, exp);
            for (int i = 0; i < gd2; i++) begin
                @(negedge clk);
                check(mem_req && mem_we && mem_wdata == exp, "R7", mem_wdata, exp);
            end
            mem_gnt = 1'b1;
            @(negedge clk);
            mem_gnt = 1'b0;
        end else begin
            check(!mem_req, "R6", {31'd0, mem_req}, 32'd0);
        end
        check(done, "R8", {31'd0, done}, 32'd1);
        check(result == exp, tag, result, exp);
        check(result_idx == ix, "R8", {27'd0, result_idx}, {27'd0, ix});
        got = result;
        @(negedge clk);
        check(!done && !busy && !mem_req, poke ? "R11" : "R8", {29'd0, done, busy, mem_req}, 32'd0);
        if (st) m_fv = 1'b0;
        else begin m_fv = 1'b1; m_fi = ix; m_fd = exp; end
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual %h expected %h", 32'd0, 32'd1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r1, r2, e;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(!busy && !mem_req && !done, "R12", {29'd0, busy, mem_req, done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !mem_req && !done, "R12", {29'd0, busy, mem_req, done}, 32'd0);

        // directed: every direction and offset
        for (int s = 0; s < 2; s++)
            for (int l = 0; l < 2; l++)
                for (int o = 0; o < 4; o++) begin
                    run_op(s[0], l[0], 32'h8000_1230 + o, 32'hA1B2_C3D4,
                           5'(10 + o), 32'h1122_3344, o % 3, (o + 1) % 3, o % 2, 1'b0, r1);
                end

        // R9: left then right to the same register merges into the first result
        run_op(1'b0, 1'b1, 32'h0000_0101, 32'hDEAD_BEEF, 5'd7, 32'h5566_7788, 0, 0, 0, 1'b0, r1);
        run_op(1'b0, 1'b0, 32'h0000_0104, 32'h0BAD_F00D, 5'd7, 32'h99AA_BBCC, 1, 1, 0, 1'b0, r2);
        e = ref_merge(1'b0, 1'b0, 0, 32'h99AA_BBCC, r1);
        check(r2 == e, "R9", r2, e);
        run_op(1'b0, 1'b0, 32'h0000_0106, 32'h0BAD_F00D, 5'd7, 32'h99AA_BBCC, 0, 0, 0, 1'b0, r2);
        e = ref_merge(1'b0, 1'b0, 2, 32'h99AA_BBCC, 32'h99AA_BBCC);
        check(r2 == e, "R9", r2, e);

        // R10: other index uses reg_in; store cancels forwarding
        run_op(1'b0, 1'b0, 32'h0000_0203, 32'h1357_9BDF, 5'd8, 32'h2468_ACE0, 0, 0, 0, 1'b0, r2);
        e = ref_merge(1'b0, 1'b0, 3, 32'h2468_ACE0, 32'h1357_9BDF);
        check(r2 == e, "R10", r2, e);
        run_op(1'b1, 1'b1, 32'h0000_0300, 32'hCAFE_0001, 5'd8, 32'h0F0F_0F0F, 0, 0, 0, 1'b0, r1);
        run_op(1'b0, 1'b1, 32'h0000_0202, 32'h7777_6666, 5'd8, 32'hFEDC_BA98, 0, 0, 0, 1'b0, r2);
        e = ref_merge(1'b0, 1'b1, 2, 32'hFEDC_BA98, 32'h7777_6666);
        check(r2 == e, "R10", r2, e);

        // R11: start pulses while busy are ignored
        run_op(1'b1, 1'b0, 32'h0000_0401, 32'h0102_0304, 5'd3, 32'hAABB_CCDD, 3, 1, 1, 1'b1, r1);
        run_op(1'b0, 1'b1, 32'h0000_0502, 32'h0102_0304, 5'd4, 32'hAABB_CCDD, 2, 0, 0, 1'b1, r1);

        // constrained random
        for (int n = 0; n < 400; n++) begin
            run_op(1'($urandom), 1'($urandom), $urandom, $urandom,
                   5'($urandom_range(1, 3)), $urandom,
                   int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                   int'($urandom_range(0, 3)), 1'($urandom_range(0, 7) == 0), r1);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule